// File: doc/BRIEF.md
# Real-Time Clock Seconds Counter

This block holds the elapsed-seconds value of a real-time clock. An external prescaler supplies a one-cycle tick strobe once per second. While counting is enabled and the stored time is valid, each tick advances the count by one. Two flags qualify the time. The invalid flag is raised by reset. The overflow flag is raised when the count wraps past its largest value. While either flag is high, the count stops and the read port returns zero.

Software changes the time through a write port. A write takes effect only while counting is disabled. It loads the new value and clears both flags, and this is the only way to clear them. Zero is an accepted value to load, even though on readback it looks the same as a masked invalid time. A status word reports the two flags at fixed bit positions.

Top module: `rtc_sec_counter`

## Requirements
- R1: After reset the read port returns 0x00000000 and the status word reads 0x00000001.
- R2: With counting enabled and both flags clear, each cycle with the tick strobe high adds one to the count, and cycles without the strobe leave it unchanged.
- R3: While the invalid flag or the overflow flag is set, the read port returns zero and ticks do not change the count.
- R4: While counting is enabled, software writes have no effect on the count or on the flags.
- R5: A write while counting is disabled loads the written value into the count and clears both flags in the same cycle.
- R6: While counting is disabled, the tick strobe has no effect on the count.
- R7: A tick that takes the count from 0xFFFFFFFF to zero sets the overflow flag. Counting then stays stopped until a write made while counting is disabled.
- R8: Writing zero while counting is disabled is accepted: the flags clear, the read port returns zero, and counting resumes from zero.
- R9: The status word carries the invalid flag in bit 0 and the overflow flag in bit 1. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| count_en_i | input | 1 | Counting enable; high makes the count read-only |
| tick_i | input | 1 | One-cycle seconds strobe from the prescaler |
| wr_en_i | input | 1 | Software write strobe for the count |
| wr_data_i | input | 32 | Value to load into the count |
| rd_data_o | output | 32 | Count as seen by software; zero while either flag is set |
| status_o | output | 32 | Status word: bit 0 is the invalid flag, bit 1 is the overflow flag |

## Verification
The hardest state to reach from the ports is the wrap, because normal ticking would take four billion strobes to get there. The bench disables counting, loads 0xFFFFFFFE, then enables counting and sends two ticks. It then checks that the overflow flag rises, that the read port masks to zero, and that neither further ticks nor writes made while counting is enabled bring the flag down. Only a write made while counting is disabled restores a readable count.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
  localparam int STAT_W  = 32;
  localparam int INV_BIT = 0;
  localparam int OVF_BIT = 1;
endpackage

// File: rtl/rtcs_count_core.sv
module rtcs_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = load_i | step_i;
    cnt_d  = load_i ? load_val_i : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = step_i & (cnt_q == CNT_MAX);
endmodule

// File: rtl/rtcs_flag_ctrl.sv
module rtcs_flag_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic wrap_i,
  output logic invalid_o,
  output logic overflow_o
);
  logic inv_q, inv_d, ovf_q, ovf_d;

  always_comb begin
    inv_d = inv_q & ~clear_i;
    ovf_d = clear_i ? 1'b0 : (ovf_q | wrap_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_q <= 1'b1;
      ovf_q <= 1'b0;
    end else begin
      inv_q <= inv_d;
      ovf_q <= ovf_d;
    end
  end

  assign invalid_o  = inv_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/rtcs_read_mask.sv
module rtcs_read_mask
  import rtcs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              invalid_i,
  input  logic              overflow_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic [STAT_W-1:0] status_o
);
  always_comb begin
    rd_data_o = (invalid_i | overflow_i) ? '0 : cnt_i;
    status_o           = '0;
    status_o[INV_BIT]  = invalid_i;
    status_o[OVF_BIT]  = overflow_i;
  end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
  import rtcs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              count_en_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic [STAT_W-1:0] status_o
);
  logic             load, step, wrap, inv, ovf;
  logic [CNT_W-1:0] cnt_q;

  // Writes land only while counting is stopped; ticks advance only valid time.
  assign load = wr_en_i & ~count_en_i;
  assign step = count_en_i & tick_i & ~inv & ~ovf;

  rtcs_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (wr_data_i),
    .step_i     (step),
    .cnt_o      (cnt_q),
    .wrap_o     (wrap)
  );

  rtcs_flag_ctrl u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (load),
    .wrap_i     (wrap),
    .invalid_o  (inv),
    .overflow_o (ovf)
  );

  rtcs_read_mask #(.CNT_W(CNT_W)) u_mask (
    .cnt_i      (cnt_q),
    .invalid_i  (inv),
    .overflow_i (ovf),
    .rd_data_o  (rd_data_o),
    .status_o   (status_o)
  );
endmodule

// File: rtl/rtcs_checker.sv
module rtcs_checker
  import rtcs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              count_en_i,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [CNT_W-1:0]  wr_data_i,
  input logic [CNT_W-1:0]  rd_data_o,
  input logic [STAT_W-1:0] status_o,
  input logic [CNT_W-1:0]  cnt_i
);
  logic flagged;
  assign flagged = status_o[INV_BIT] | status_o[OVF_BIT];

  assert_increment_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_i && tick_i && !flagged && cnt_i != {CNT_W{1'b1}})
    |=> (cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

  assert_masked_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flagged |-> (rd_data_o == '0));

  assert_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_i && flagged) |=> $stable(cnt_i));

  assert_write_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_i && !tick_i) |=> ($stable(cnt_i) && $stable(status_o)));

  assert_load_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_en_i && wr_en_i)
    |=> (status_o[1:0] == 2'b00 && cnt_i == $past(wr_data_i)));

  assert_tick_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_en_i && !wr_en_i) |=> ($stable(cnt_i) && $stable(status_o)));

  assert_wrap_sets_ovf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en_i && tick_i && !flagged && cnt_i == {CNT_W{1'b1}})
    |=> (status_o[OVF_BIT] && cnt_i == '0));

  assert_upper_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[STAT_W-1:2] == '0);
endmodule

bind rtc_sec_counter rtcs_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .count_en_i (count_en_i),
  .tick_i     (tick_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .status_o   (status_o),
  .cnt_i      (cnt_q)
);

// File: tb/tb_rtc_sec_counter.sv
`timescale 1ns/1ps
module tb_rtc_sec_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en, tick, wr;
  logic [31:0] wdata;
  logic [31:0] rd, st;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_sec_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .count_en_i(en), .tick_i(tick),
    .wr_en_i(wr), .wr_data_i(wdata), .rd_data_o(rd), .status_o(st)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // One clock: inputs applied at the falling edge, released after the rising edge.
  task automatic cyc(input logic e, input logic t, input logic w, input logic [31:0] d);
    @(negedge clk);
    en = e; tick = t; wr = w; wdata = d;
    @(posedge clk);
    #1;
    tick = 1'b0; wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 read after reset", rd, 32'h0);
    check("R1 R9 status after reset", st, 32'h1);
  endtask

  task automatic t_invalid_frozen();
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, '0);
    check("R3 read while invalid", rd, 32'h0);
    check("R3 status stays invalid", st, 32'h1);
  endtask

  task automatic t_load();
    cyc(0, 0, 1, 32'h0000_0100);
    check("R5 loaded value", rd, 32'h100);
    check("R5 flags cleared", st, 32'h0);
  endtask

  task automatic t_tick_disabled();
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, '0);
    check("R6 tick while disabled", rd, 32'h100);
  endtask

  task automatic t_count();
    cyc(1, 1, 0, '0);
    cyc(1, 0, 0, '0);
    cyc(1, 0, 0, '0);
    check("R2 idle cycles hold", rd, 32'h101);
    cyc(1, 1, 0, '0);
    cyc(1, 1, 0, '0);
    check("R2 three ticks", rd, 32'h103);
  endtask

  task automatic t_write_enabled();
    cyc(1, 0, 1, 32'hDEAD_BEEF);
    check("R4 write while enabled", rd, 32'h103);
    cyc(1, 1, 1, 32'h1234_5678);
    check("R4 write with tick while enabled", rd, 32'h104);
    check("R4 flags unchanged", st, 32'h0);
  endtask

  task automatic t_wrap();
    cyc(0, 0, 1, 32'hFFFF_FFFE);
    cyc(1, 1, 0, '0);
    check("R2 count to max", rd, 32'hFFFF_FFFF);
    cyc(1, 1, 0, '0);
    check("R7 read after wrap", rd, 32'h0);
    check("R7 R9 overflow status", st, 32'h2);
    cyc(1, 1, 0, '0);
    cyc(1, 0, 1, 32'h0000_0077);
    check("R7 overflow held against ticks and enabled write", st, 32'h2);
    check("R3 read masked on overflow", rd, 32'h0);
    cyc(0, 0, 1, 32'h0000_0005);
    check("R5 load clears overflow", st, 32'h0);
    check("R5 value after overflow", rd, 32'h5);
  endtask

  task automatic t_zero();
    cyc(0, 0, 1, 32'h0);
    check("R8 zero load status", st, 32'h0);
    check("R8 zero load read", rd, 32'h0);
    cyc(1, 1, 0, '0);
    check("R8 counts from zero", rd, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; tick = 1'b0; wr = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_invalid_frozen();
    cyc(0, 0, 0, '0);
    t_load();
    t_tick_disabled();
    t_count();
    t_write_enabled();
    t_wrap();
    t_zero();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule